// File: doc/BRIEF.md
# Interruptible Block XOR Scrambler

This engine copies a block of 16-bit words from one memory region to another and XORs every word with a key on the way. Two key words are supplied. The first word handled takes the first key, the second word takes the second key, and the two keys keep alternating from there. The block is walked from its highest index down to index zero. A word read from source offset k is always written to destination offset k.

One start pulse loads five arguments: the source base, the destination base, the word count and the two keys. The engine then drives a single memory port. Each read request returns its data a fixed number of cycles later, and each write carries its address and data in the same cycle.

After every completed pair of words the engine checks for an interrupt. If one is pending and the wake-up-disable count is zero, the engine stops and pulses `yieldPulse`. The unprocessed count stays visible on `remainCount`. The caller resumes the operation by issuing a new start with that count and the same arguments.

Top module: `blockXorScrambler`

## Requirements
- R1: After reset, `busy`, `donePulse`, `yieldPulse`, `memRdReq` and `memWrEn` are all low.
- R2: For a count N, exactly N words are written, at destination indices N-1, N-2, …, 0 in that order. Each written value is the source word at the same index XOR the selected key.
- R3: Key selection follows processing order, not address. Words processed in the 1st, 3rd, 5th, … positions use key A (`startKeyA`). Words in the 2nd, 4th, … positions use key B (`startKeyB`).
- R4: A count of zero produces no read and no write. `donePulse` appears 6 cycles after the cycle in which the start was accepted.
- R5: The count is tested again before the second word of each pair. An odd count therefore ends right after its last word, even if an interrupt is open. `donePulse` comes 6+12·N cycles after acceptance.
- R6: The k-th processed word (k from 0) is read 6+12·k cycles after acceptance and written 16+12·k cycles after acceptance. Read data is taken 2 cycles after the request.
- R7: A yield is checked in the write cycle of each pair's second word. It happens only when `irqPending` is high and `wakeDisable` is zero in that cycle. `yieldPulse` follows one cycle later, with `remainCount` equal to the count not yet processed, which may be zero.
- R8: While `wakeDisable` is nonzero, a pending interrupt does not stop the operation.
- R9: Restarting with the reported remainder and the same arguments continues at the next lower index. The restart again begins with key A.
- R10: `busy` is high from the cycle after acceptance until the end pulse. A start presented while `busy` is high has no effect on the writes or on the end of the operation.
- R11: `donePulse` and `yieldPulse` each last one cycle and never occur together. At `donePulse`, `remainCount` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start request, accepted while busy is low |
| startSrc | input | 16 | Source base address |
| startDst | input | 16 | Destination base address |
| startCount | input | 16 | Number of words to process |
| startKeyA | input | 16 | Key for 1st, 3rd, … processed words |
| startKeyB | input | 16 | Key for 2nd, 4th, … processed words |
| irqPending | input | 1 | Interrupt pending |
| wakeDisable | input | 8 | Wake-up-disable count; yield allowed only at zero |
| memRdReq | output | 1 | Read request |
| memRdAddr | output | 16 | Read address |
| memRdData | input | 16 | Read data, valid 2 cycles after request |
| memWrEn | output | 1 | Write strobe |
| memWrAddr | output | 16 | Write address |
| memWrData | output | 16 | Write data |
| busy | output | 1 | Operation in progress |
| donePulse | output | 1 | One-cycle normal completion |
| yieldPulse | output | 1 | One-cycle stop for interrupt; re-issue needed |
| remainCount | output | 16 | Words still to process |

## Verification
Every result has a fixed due cycle measured from start acceptance: the k-th write at +16+12k, the done pulse at +6+12N, and the yield pulse one cycle after the pair's second write. The driver records the acceptance edge and stamps each expected write with its due cycle. The monitor compares address, data and cycle of every write it sees at the falling edge. End pulses and the reported remainder are checked in the exact cycle of the pulse, and the cycle after it is checked for the pulse's end.

// File: rtl/scrPkg.sv
package scrPkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CHECK,
    ST_RDREQ,
    ST_RDWAIT,
    ST_XOR,
    ST_STADDR,
    ST_PAD,
    ST_WRITE,
    ST_DONE,
    ST_YIELD
  } scrState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadArgs;
    logic clearArgs;
    logic decCount;
    logic captureXor;
    logic latchWrAddr;
    logic useKeyB;
  } scrStrobes_t;

endpackage

// File: rtl/scrDatapath.sv
module scrDatapath
  import scrPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  scrStrobes_t       strobes,
  input  logic [ADDR_W-1:0] startSrc,
  input  logic [ADDR_W-1:0] startDst,
  input  logic [CNT_W-1:0]  startCount,
  input  logic [DATA_W-1:0] startKeyA,
  input  logic [DATA_W-1:0] startKeyB,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic [CNT_W-1:0]  remainCount,
  output logic              countZero
);

  logic [ADDR_W-1:0] srcBase, dstBase, wrAddrQ;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] keyA, keyB, resultQ;
  logic [DATA_W-1:0] keySel;
  logic [ADDR_W-1:0] cntAsAddr;

  assign cntAsAddr = ADDR_W'(cnt);
  assign keySel    = strobes.useKeyB ? keyB : keyA;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcBase <= '0;
      dstBase <= '0;
      cnt     <= '0;
      keyA    <= '0;
      keyB    <= '0;
      resultQ <= '0;
      wrAddrQ <= '0;
    end else if (strobes.loadArgs) begin
      srcBase <= startSrc;
      dstBase <= startDst;
      cnt     <= startCount;
      keyA    <= startKeyA;
      keyB    <= startKeyB;
    end else if (strobes.clearArgs) begin
      srcBase <= '0;
      dstBase <= '0;
      cnt     <= '0;
      keyA    <= '0;
      keyB    <= '0;
    end else begin
      if (strobes.decCount)    cnt     <= cnt - CNT_W'(1);
      if (strobes.captureXor)  resultQ <= memRdData ^ keySel;
      if (strobes.latchWrAddr) wrAddrQ <= dstBase + cntAsAddr;
    end
  end

  // after the decrement the count register is the current index
  assign memRdAddr   = srcBase + cntAsAddr;
  assign memWrAddr   = wrAddrQ;
  assign memWrData   = resultQ;
  assign remainCount = cnt;
  assign countZero   = (cnt == '0);

endmodule

// File: rtl/scrCtrl.sv
module scrCtrl
  import scrPkg::*;
#(
  parameter int WDC_W     = 8,
  parameter int RD_LAT    = 2,
  parameter int SETUP_CYC = 5,
  parameter int WORD_CYC  = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic             countZero,
  input  logic             irqPending,
  input  logic [WDC_W-1:0] wakeDisable,
  output scrStrobes_t      strobes,
  output logic             memRdReq,
  output logic             memWrEn,
  output logic             busy,
  output logic             donePulse,
  output logic             yieldPulse
);

  // fixed per-word slots: check, request, wait, xor, store address, write
  localparam int PAD_CYC = WORD_CYC - 4 - RD_LAT;
  localparam int TICK_W  = $clog2(SETUP_CYC + WORD_CYC + 1);

  generate
    if (RD_LAT < 2 || PAD_CYC < 1 || SETUP_CYC < 1) begin : g_badParam
      $error("scrCtrl: RD_LAT must be >= 2 and WORD_CYC must leave at least one pad cycle");
    end
  endgenerate

  scrState_e        state, stateNext;
  logic [TICK_W-1:0] tick, tickNext;
  logic             secondWord, secondWordNext;
  logic             yieldGate;

  assign yieldGate = irqPending && (wakeDisable == '0);

  always_comb begin
    stateNext      = state;
    tickNext       = tick;
    secondWordNext = secondWord;
    strobes        = '0;
    strobes.useKeyB = secondWord;
    unique case (state)
      ST_IDLE, ST_DONE, ST_YIELD: begin
        stateNext = ST_IDLE;
        if (startValid) begin
          strobes.loadArgs = 1'b1;
          secondWordNext   = 1'b0;
          tickNext         = '0;
          stateNext        = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (tick == TICK_W'(SETUP_CYC - 1)) begin
          tickNext  = '0;
          stateNext = ST_CHECK;
        end else begin
          tickNext = tick + TICK_W'(1);
        end
      end
      ST_CHECK: begin
        if (countZero) begin
          strobes.clearArgs = 1'b1;
          stateNext         = ST_DONE;
        end else begin
          strobes.decCount = 1'b1;
          stateNext        = ST_RDREQ;
        end
      end
      ST_RDREQ: begin
        tickNext  = '0;
        stateNext = ST_RDWAIT;
      end
      ST_RDWAIT: begin
        if (tick == TICK_W'(RD_LAT - 2)) begin
          stateNext = ST_XOR;
        end else begin
          tickNext = tick + TICK_W'(1);
        end
      end
      ST_XOR: begin
        strobes.captureXor = 1'b1;
        stateNext          = ST_STADDR;
      end
      ST_STADDR: begin
        strobes.latchWrAddr = 1'b1;
        tickNext            = '0;
        stateNext           = ST_PAD;
      end
      ST_PAD: begin
        if (tick == TICK_W'(PAD_CYC - 1)) begin
          stateNext = ST_WRITE;
        end else begin
          tickNext = tick + TICK_W'(1);
        end
      end
      ST_WRITE: begin
        if (!secondWord) begin
          secondWordNext = 1'b1;
          stateNext      = ST_CHECK;
        end else begin
          secondWordNext = 1'b0;
          stateNext      = yieldGate ? ST_YIELD : ST_CHECK;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      tick       <= '0;
      secondWord <= 1'b0;
    end else begin
      state      <= stateNext;
      tick       <= tickNext;
      secondWord <= secondWordNext;
    end
  end

  assign memRdReq   = (state == ST_RDREQ);
  assign memWrEn    = (state == ST_WRITE);
  assign donePulse  = (state == ST_DONE);
  assign yieldPulse = (state == ST_YIELD);
  assign busy       = !(state inside {ST_IDLE, ST_DONE, ST_YIELD});

  // R11: end pulses never coincide
  p_pulse_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(donePulse && yieldPulse));

  // R11: completion lasts a single cycle
  p_done_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R7: a yield only follows an open interrupt gate
  p_yield_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    yieldPulse |-> ($past(irqPending) && $past(wakeDisable) == '0));

  // R10: busy only falls into an end pulse, never silently
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || donePulse || yieldPulse));

  // R10: no memory traffic outside an operation
  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memRdReq && !memWrEn));

endmodule

// File: rtl/blockXorScrambler.sv
module blockXorScrambler
  import scrPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 16,
  parameter int WDC_W     = 8,
  parameter int RD_LAT    = 2,
  parameter int SETUP_CYC = 5,
  parameter int WORD_CYC  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [ADDR_W-1:0] startSrc,
  input  logic [ADDR_W-1:0] startDst,
  input  logic [CNT_W-1:0]  startCount,
  input  logic [DATA_W-1:0] startKeyA,
  input  logic [DATA_W-1:0] startKeyB,
  input  logic              irqPending,
  input  logic [WDC_W-1:0]  wakeDisable,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              busy,
  output logic              donePulse,
  output logic              yieldPulse,
  output logic [CNT_W-1:0]  remainCount
);

  scrStrobes_t strobes;
  logic        countZero;

  scrCtrl #(
    .WDC_W    (WDC_W),
    .RD_LAT   (RD_LAT),
    .SETUP_CYC(SETUP_CYC),
    .WORD_CYC (WORD_CYC)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .countZero  (countZero),
    .irqPending (irqPending),
    .wakeDisable(wakeDisable),
    .strobes    (strobes),
    .memRdReq   (memRdReq),
    .memWrEn    (memWrEn),
    .busy       (busy),
    .donePulse  (donePulse),
    .yieldPulse (yieldPulse)
  );

  scrDatapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .startSrc   (startSrc),
    .startDst   (startDst),
    .startCount (startCount),
    .startKeyA  (startKeyA),
    .startKeyB  (startKeyB),
    .memRdData  (memRdData),
    .memRdAddr  (memRdAddr),
    .memWrAddr  (memWrAddr),
    .memWrData  (memWrData),
    .remainCount(remainCount),
    .countZero  (countZero)
  );

endmodule

// File: tb/tb_blockXorScrambler.sv
module tb_blockXorScrambler;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [15:0] startSrc = '0, startDst = '0, startCount = '0;
  logic [15:0] startKeyA = '0, startKeyB = '0;
  logic        irqPending = 1'b0;
  logic [7:0]  wakeDisable = '0;
  logic        memRdReq, memWrEn, busy, donePulse, yieldPulse;
  logic [15:0] memRdAddr, memWrAddr, memWrData, remainCount;
  logic [15:0] memRdData = '0;

  blockXorScrambler dut (
    .clk(clk), .rstN(rstN), .startValid(startValid),
    .startSrc(startSrc), .startDst(startDst), .startCount(startCount),
    .startKeyA(startKeyA), .startKeyB(startKeyB),
    .irqPending(irqPending), .wakeDisable(wakeDisable),
    .memRdReq(memRdReq), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .busy(busy), .donePulse(donePulse), .yieldPulse(yieldPulse),
    .remainCount(remainCount)
  );

  always #2 clk = ~clk;

  int vectors = 0;
  int errors  = 0;
  int cyc     = 0;
  int rdSeen  = 0;
  int startCyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] srcVal(logic [15:0] a);
    return (a * 16'h9E37) ^ 16'h5A5A;
  endfunction

  // memory model: data valid 2 cycles after the request cycle
  logic        p1 = 1'b0;
  logic [15:0] a1 = '0;
  always @(posedge clk) begin
    p1 <= memRdReq;
    a1 <= memRdAddr;
    if (p1) memRdData <= srcVal(a1);
  end

  typedef struct {
    logic [15:0] addr;
    logic [15:0] data;
    int          due;
  } expWr_t;
  expWr_t expQ[$];

  task automatic check(bit ok, string req, string msg);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // monitor: pops expected writes as the design produces them
  always @(negedge clk) begin
    if (rstN && memRdReq) rdSeen++;
    if (rstN && memWrEn) begin
      if (expQ.size() == 0) begin
        check(0, "R2", $sformatf("unexpected write addr %h data %h, expected none",
                                 memWrAddr, memWrData));
      end else begin
        expWr_t e;
        e = expQ.pop_front();
        check(memWrAddr == e.addr && memWrData == e.data, "R2/R3",
              $sformatf("write got %h/%h expected %h/%h", memWrAddr, memWrData, e.addr, e.data));
        check(cyc == e.due, "R6",
              $sformatf("write cycle got %0d expected %0d", cyc - startCyc, e.due - startCyc));
      end
    end
    if (rstN && donePulse && yieldPulse)
      check(0, "R11", "done and yield together, expected exclusive");
  end

  // driver: launch one operation and push its expected writes
  task automatic startOp(logic [15:0] src, logic [15:0] dst, logic [15:0] cnt,
                         logic [15:0] ka, logic [15:0] kb, int nWrites);
    @(negedge clk);
    startSrc = src; startDst = dst; startCount = cnt;
    startKeyA = ka; startKeyB = kb; startValid = 1'b1;
    rdSeen = 0;
    @(posedge clk);
    #1;
    startValid = 1'b0;
    startCyc = cyc;
    for (int k = 0; k < nWrites; k++) begin
      expWr_t e;
      logic [15:0] idx;
      idx    = cnt - 16'(k) - 16'd1;
      e.addr = dst + idx;
      e.data = srcVal(src + idx) ^ ((k % 2 == 0) ? ka : kb);
      e.due  = startCyc + 16 + 12 * k;
      expQ.push_back(e);
    end
  endtask

  task automatic waitEnd(bit expYield, int relCyc, logic [15:0] expRem, string req);
    int  n = 0;
    bit  got = 0;
    bit  busyOk = 1;
    bit  wasYield = 0;
    int  atCyc = 0;
    logic [15:0] rem = '0;
    while (!got && n < 3000) begin
      @(negedge clk);
      n++;
      if (donePulse || yieldPulse) begin
        got = 1; wasYield = yieldPulse; atCyc = cyc - startCyc; rem = remainCount;
      end else if (!busy) begin
        busyOk = 0;
      end
    end
    check(got, req, "no end pulse, expected one");
    check(wasYield == expYield, req, $sformatf("end kind yield=%0d expected %0d", wasYield, expYield));
    check(atCyc == relCyc, req, $sformatf("end cycle %0d expected %0d", atCyc, relCyc));
    check(rem == expRem, req, $sformatf("remainCount %0d expected %0d", rem, expRem));
    check(busyOk, "R10", "busy low during operation, expected high");
    check(expQ.size() == 0, "R2", $sformatf("%0d writes missing, expected 0", expQ.size()));
    expQ.delete();
    @(negedge clk);
    check(!donePulse && !yieldPulse, "R11",
          $sformatf("pulse lasted 2 cycles: done=%0d yield=%0d expected 0", donePulse, yieldPulse));
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog", "run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] savedRem;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(!busy && !donePulse && !yieldPulse && !memRdReq && !memWrEn, "R1",
          $sformatf("reset outputs busy=%0d done=%0d yield=%0d rd=%0d wr=%0d expected all 0",
                    busy, donePulse, yieldPulse, memRdReq, memWrEn));
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !memRdReq && !memWrEn, "R1", "outputs active after reset, expected idle");

    // R4: zero count
    startOp(16'h0010, 16'h0080, 16'd0, 16'h1111, 16'h2222, 0);
    waitEnd(0, 6, 16'd0, "R4");
    check(rdSeen == 0, "R4", $sformatf("%0d reads for zero count, expected 0", rdSeen));

    // R2 R3 R5 R6: odd count, plus start while busy (R10)
    startOp(16'h0020, 16'h0090, 16'd5, 16'hA5C3, 16'h0F0F, 5);
    repeat (10) @(negedge clk);
    startValid = 1'b1; startCount = 16'd9; startSrc = 16'h0033; startKeyA = 16'hFFFF;
    @(negedge clk);
    startValid = 1'b0;
    waitEnd(0, 6 + 12 * 5, 16'd0, "R5");

    // R8: interrupt pending but wake-up disabled
    irqPending = 1'b1; wakeDisable = 8'd3;
    startOp(16'h0004, 16'h00A0, 16'd4, 16'h1234, 16'h8001, 4);
    waitEnd(0, 6 + 12 * 4, 16'd0, "R8");

    // R7: yield after first pair, then R9 resume
    wakeDisable = 8'd0;
    startOp(16'h0030, 16'h00B0, 16'd6, 16'hBEEF, 16'h7777, 2);
    waitEnd(1, 29, 16'd4, "R7");
    savedRem = remainCount;
    irqPending = 1'b0;
    startOp(16'h0030, 16'h00B0, savedRem, 16'hBEEF, 16'h7777, 4);
    waitEnd(0, 6 + 12 * 4, 16'd0, "R9");

    // R5: single word with interrupt open ends normally
    irqPending = 1'b1;
    startOp(16'h0040, 16'h00C0, 16'd1, 16'h0101, 16'h0202, 1);
    waitEnd(0, 18, 16'd0, "R5");

    // R7: yield may leave zero remaining; restart then finishes at once
    startOp(16'h0048, 16'h00D0, 16'd2, 16'hC001, 16'h3003, 2);
    waitEnd(1, 29, 16'd0, "R7");
    irqPending = 1'b0;
    startOp(16'h0048, 16'h00D0, 16'd0, 16'hC001, 16'h3003, 0);
    waitEnd(0, 6, 16'd0, "R9");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule